// File: doc/BRIEF.md
# Character Display Write Master with Busy-Flag Polling

This block sits between a host and a parallel character display controller. The host hands over one byte at a time, tagged as either a command or a character. Before every transfer the block reads the display's status word and checks the busy bit. It pulses the enable line to write the byte only after a read reports the display as free. No fixed wait times are used, so throughput follows the real execution time of each display operation.

The display link has five signals: an 8-bit data bus split into output, output-enable and input, a register-select line, a read/write line and an enable strobe. Every strobe (status read or write) keeps enable high for a set number of clocks. Register-select and read/write settle one clock before enable rises. If the display stays busy for too many status reads in a row, the block drops the pending byte and raises a sticky error flag.

Top module: `lcd_busy_writer`

## Requirements
- R1: While reset is held and right after it: `req_ready`=1, `lcd_en`=0, `lcd_d_oe`=0, `poll_err`=0.
- R2: A request is taken on a clock where `req_valid` and `req_ready` are both 1. `req_ready` stays 0 until the write strobe ends. With the display idle, `req_ready` is 0 for exactly 2*EN_HOLD+2 cycles.
- R3: A status read drives `lcd_rs`=0 and `lcd_rw`=1 and releases the bus (`lcd_d_oe`=0). The bus is driven only when `lcd_rw`=0.
- R4: Only bit 7 of the status word is used, and the other bits are ignored. 1 means busy and 0 means ready. A write strobe starts only after a status read that returned bit 7 = 0, so no byte reaches the display while it is busy.
- R5: Each status read that returns busy is followed by one clock with enable low, then another read. Every extra read adds exactly EN_HOLD+1 cycles to the time `req_ready` stays low.
- R6: A write drives `lcd_rw`=0 and `lcd_d_oe`=1 and puts the stored byte on `lcd_d_o`. `lcd_rs`=1 selects the data register for a character and `lcd_rs`=0 selects the instruction register for a command.
- R7: Every enable pulse lasts exactly EN_HOLD clocks (EN_HOLD ≥ 3). `lcd_rs` and `lcd_rw` hold the same value for the clock before enable rises.
- R8: After POLL_LIMIT busy reads in a row, the request is dropped with no write. `poll_err` goes to 1 and `req_ready` returns after POLL_LIMIT*(EN_HOLD+1) cycles.
- R9: `poll_err` stays 1 until the next request is accepted, which clears it.
- R10: A `req_valid` pulse, or a change of `req_byte`/`req_is_data`, while `req_ready`=0 has no effect. The byte written is the one taken at acceptance, and only one write happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host offers a byte |
| req_ready | output | 1 | Block can take a byte |
| req_is_data | input | 1 | 1 = character (data register), 0 = command |
| req_byte | input | 8 | Byte to write |
| lcd_rs | output | 1 | Register select, 0 = instruction/status, 1 = data |
| lcd_rw | output | 1 | 1 = read, 0 = write |
| lcd_en | output | 1 | Enable strobe |
| lcd_d_o | output | 8 | Bus value driven during writes |
| lcd_d_oe | output | 1 | Bus output enable |
| lcd_d_i | input | 8 | Bus value returned by the display |
| poll_err | output | 1 | Sticky busy-timeout flag |

## Verification
The display model returns a nonzero pattern in the low status bits, so a design that tests the whole status byte instead of bit 7 stalls or misbehaves. Requests are tried with the display idle, which gives the exact minimum latency, and with busy windows of several lengths, which force one or more extra reads. The latency must then grow in whole read periods. The byte mix covers commands and characters, data values with bit 7 set and clear, and all-zero and all-one bytes, so the register-select choice and the data path can be told apart from the busy bit. A stuck-busy display checks the timeout count and the sticky error, and a stray request during a transfer checks that the latched byte is not disturbed.

// File: rtl/lcdm_pkg.sv
package lcdm_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_PSET = 3'd1,
    S_PEN  = 3'd2,
    S_WSET = 3'd3,
    S_WEN  = 3'd4
  } state_t;

  localparam int BUSY_BIT = 7;

  // counter width able to hold values 0..n
  function automatic int cnt_w(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/lcdm_strobe_timer.sv
module lcdm_strobe_timer #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic last
);
  localparam int W = lcdm_pkg::cnt_w(HOLD);
  localparam logic [W-1:0] LAST_V = W'(HOLD - 1);

  logic [W-1:0] cnt;

  assign last = run && (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt <= '0;
    else if (run && !last)   cnt <= cnt + 1'b1;
    else                     cnt <= '0;
  end
endmodule

// File: rtl/lcdm_poll_guard.sv
module lcdm_poll_guard #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic busy_seen,
  output logic limit_hit
);
  localparam int W = lcdm_pkg::cnt_w(LIMIT);
  localparam logic [W-1:0] LAST_V = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign limit_hit = busy_seen && (cnt == LAST_V);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (busy_seen)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/lcd_busy_writer.sv
module lcd_busy_writer
  import lcdm_pkg::*;
#(
  parameter int EN_HOLD    = 4,
  parameter int POLL_LIMIT = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_is_data,
  input  logic [7:0] req_byte,
  output logic       lcd_rs,
  output logic       lcd_rw,
  output logic       lcd_en,
  output logic [7:0] lcd_d_o,
  output logic       lcd_d_oe,
  input  logic [7:0] lcd_d_i,
  output logic       poll_err
);
  localparam int EW = cnt_w(EN_HOLD + 1);
  localparam int PW = cnt_w(POLL_LIMIT + 1);
  localparam logic [EW-1:0] HOLD_V  = EW'(EN_HOLD);
  localparam logic [PW-1:0] LIMIT_V = PW'(POLL_LIMIT);

  state_t     state;
  logic       is_data_q;
  logic [7:0] byte_q;
  logic       err_q;

  // named internal events
  logic accept, en_run, strobe_last, poll_done, busy_now, busy_seen, limit_hit;
  logic in_read, in_write;
  logic unused_status_bits;

  assign accept    = req_valid && req_ready;
  assign in_read   = (state == S_PSET) || (state == S_PEN);
  assign in_write  = (state == S_WSET) || (state == S_WEN);
  assign en_run    = (state == S_PEN) || (state == S_WEN);
  assign poll_done = (state == S_PEN) && strobe_last;
  assign busy_now  = lcd_d_i[BUSY_BIT];
  assign busy_seen = poll_done && busy_now;
  assign unused_status_bits = ^lcd_d_i[6:0];

  lcdm_strobe_timer #(.HOLD(EN_HOLD)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (en_run),
    .last (strobe_last)
  );

  lcdm_poll_guard #(.LIMIT(POLL_LIMIT)) u_guard (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .busy_seen(busy_seen),
    .limit_hit(limit_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      is_data_q <= 1'b0;
      byte_q    <= '0;
      err_q     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          byte_q    <= req_byte;
          is_data_q <= req_is_data;
          err_q     <= 1'b0;
          state     <= S_PSET;
        end
        S_PSET: state <= S_PEN;
        S_PEN: if (poll_done) begin
          if (!busy_now)      state <= S_WSET;
          else if (limit_hit) begin
            err_q <= 1'b1;
            state <= S_IDLE;
          end else            state <= S_PSET;
        end
        S_WSET: state <= S_WEN;
        S_WEN:  if (strobe_last) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_ready = (state == S_IDLE);
  assign lcd_en    = en_run;
  assign lcd_rw    = in_read;
  assign lcd_rs    = in_write && is_data_q;
  assign lcd_d_oe  = in_write;
  assign lcd_d_o   = in_write ? byte_q : 8'h00;
  assign poll_err  = err_q;

  // ---------------- checking state, driven apart from the FSM ----------------
  logic [EW-1:0] en_len;
  logic [PW-1:0] poll_cnt;
  logic          ready_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_len     <= '0;
      poll_cnt   <= '0;
      ready_seen <= 1'b0;
    end else begin
      en_len <= lcd_en ? en_len + 1'b1 : '0;
      if (accept) begin
        poll_cnt   <= '0;
        ready_seen <= 1'b0;
      end else if (poll_done) begin
        poll_cnt   <= poll_cnt + 1'b1;
        ready_seen <= !busy_now;
      end
    end
  end

  // R3
  bus_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_d_oe |-> !lcd_rw);

  // R7
  setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_en) |-> ($stable(lcd_rs) && $stable(lcd_rw)));

  // R7
  en_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lcd_en) |-> (en_len == HOLD_V));

  // R2
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_en |-> !req_ready);

  // R4
  wr_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(lcd_en) && !lcd_rw) |-> ready_seen);

  // R8
  err_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(poll_err) |-> (poll_cnt == LIMIT_V));

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_err && !accept) |=> poll_err);

endmodule

// File: tb/lcd_busy_writer_tb.sv
module lcd_busy_writer_tb;
  localparam int HOLD  = 3;
  localparam int LIMIT = 6;
  localparam int BASE  = 2 * HOLD + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_is_data = 1'b0;
  logic [7:0] req_byte = 8'h00;
  logic req_ready, lcd_rs, lcd_rw, lcd_en, lcd_d_oe, poll_err;
  logic [7:0] lcd_d_o, lcd_d_i;

  always #2 clk = ~clk;

  lcd_busy_writer #(.EN_HOLD(HOLD), .POLL_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_is_data(req_is_data), .req_byte(req_byte),
    .lcd_rs(lcd_rs), .lcd_rw(lcd_rw), .lcd_en(lcd_en),
    .lcd_d_o(lcd_d_o), .lcd_d_oe(lcd_d_oe), .lcd_d_i(lcd_d_i),
    .poll_err(poll_err)
  );

  // ---------------- behavioural display model ----------------
  int busy_len = 0;
  int busy_cnt = 0;
  logic stuck = 1'b0;
  logic en_q = 1'b0, rs_q = 1'b0, rw_q = 1'b0;
  int hi_len = 0;
  int contention = 0, setup_err = 0, width_err = 0, wr_busy = 0, bad_read = 0;
  int log_n = 0;
  int log_v [64];

  assign lcd_d_i = (lcd_en && lcd_rw && !lcd_rs) ? {(stuck || busy_cnt != 0), 7'h15} : 8'h00;

  always @(posedge clk) begin
    en_q <= lcd_en; rs_q <= lcd_rs; rw_q <= lcd_rw;
    hi_len <= lcd_en ? hi_len + 1 : 0;
    if (lcd_rw && lcd_d_oe) contention++;
    if (!lcd_en && en_q && hi_len != HOLD) width_err++;
    if (lcd_en && !en_q) begin
      if (lcd_rs != rs_q || lcd_rw != rw_q) setup_err++;
      if (!lcd_rw) begin
        if (busy_cnt != 0 || stuck) wr_busy++;
        if (log_n < 64) log_v[log_n] = {23'd0, lcd_rs, lcd_d_o};
        log_n++;
        busy_cnt <= busy_len;
      end else if (lcd_rs) bad_read++;
    end else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
  end

  // ---------------- bookkeeping ----------------
  int total = 0, bad = 0, cyc = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=%0d expected=<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // send one byte; count cycles with ready low; scramble inputs after accept (R10)
  task automatic send(input logic d, input logic [7:0] b, input logic noise, output int low);
    @(negedge clk);
    req_valid = 1'b1; req_is_data = d; req_byte = b;
    @(negedge clk);
    req_valid = 1'b0; req_is_data = ~d; req_byte = ~b;
    low = 0;
    while (!req_ready && low < 5000) begin
      low++;
      if (noise && low == 3) req_valid = 1'b1;
      else req_valid = 1'b0;
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  // vector: [16:9] busy window set at this write, [8] is_data, [7:0] byte
  localparam logic [16:0] VEC [8] = '{
    {8'd0,  1'b0, 8'h38},
    {8'd0,  1'b1, 8'h41},
    {8'd9,  1'b1, 8'hA5},
    {8'd0,  1'b0, 8'h01},
    {8'd17, 1'b1, 8'h80},
    {8'd0,  1'b0, 8'hFF},
    {8'd0,  1'b1, 8'h00},
    {8'd5,  1'b0, 8'h7E}
  };

  initial begin
    int low;
    int prev_busy;
    int n0;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1", "ready in reset", int'(req_ready), 1);
    chk("R1", "en in reset", int'(lcd_en), 0);
    chk("R1", "oe in reset", int'(lcd_d_oe), 0);
    chk("R1", "err in reset", int'(poll_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", int'(req_ready), 1);

    prev_busy = 0;
    for (int i = 0; i < 8; i++) begin
      busy_len = int'(VEC[i][16:9]);
      n0 = log_n;
      send(VEC[i][8], VEC[i][7:0], 1'b0, low);
      chk("R6", "write count", log_n - n0, 1);
      chk("R6", "rs+byte written", log_v[n0 % 64], int'({VEC[i][8], VEC[i][7:0]}));
      if (prev_busy == 0)
        chk("R2", "ready-low cycles idle display", low, BASE);
      else
        chk("R5", "extra polls whole periods", int'(low >= BASE && ((low - BASE) % (HOLD + 1)) == 0), 1);
      prev_busy = busy_len;
      repeat (2) @(negedge clk);
    end
    busy_len = 0;
    repeat (40) @(negedge clk);

    // R5 forced multi-poll: long busy window then immediate request
    busy_len = 30;
    send(1'b0, 8'h0C, 1'b0, low);
    busy_len = 0;
    send(1'b1, 8'h5B, 1'b0, low);
    chk("R5", "polled at least once extra", int'(low > BASE), 1);
    chk("R5", "extra polls whole periods", (low - BASE) % (HOLD + 1), 0);
    repeat (40) @(negedge clk);

    // R10 stray valid during transfer
    n0 = log_n;
    send(1'b1, 8'h3C, 1'b1, low);
    repeat (20) @(negedge clk);
    chk("R10", "single write for stray valid", log_n - n0, 1);
    chk("R10", "latched byte kept", log_v[n0 % 64], int'({1'b1, 8'h3C}));

    // R8 timeout with stuck busy
    stuck = 1'b1;
    n0 = log_n;
    send(1'b0, 8'h02, 1'b0, low);
    chk("R8", "timeout latency", low, LIMIT * (HOLD + 1));
    chk("R8", "err raised", int'(poll_err), 1);
    chk("R8", "no write on timeout", log_n - n0, 0);
    repeat (10) @(negedge clk);
    chk("R9", "err sticky while idle", int'(poll_err), 1);
    stuck = 1'b0;
    @(negedge clk);
    req_valid = 1'b1; req_is_data = 1'b1; req_byte = 8'h61;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "err cleared on accept", int'(poll_err), 0);
    repeat (30) @(negedge clk);
    chk("R9", "write after recovery", log_v[n0 % 64], int'({1'b1, 8'h61}));

    // protocol monitors from the model
    chk("R3", "bus driven during read", contention, 0);
    chk("R3", "status read with rs=1", bad_read, 0);
    chk("R4", "write while busy", wr_busy, 0);
    chk("R7", "setup violations", setup_err, 0);
    chk("R7", "enable width errors", width_err, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule